// File: doc/BRIEF.md
# SIMD Divergence Mask Stack

This block keeps the active lane mask of a SIMD core while predicated control flow sends some lanes one way and the rest another. A split instruction narrows the mask to the lanes whose predicate is true and records what is needed to come back. The matching join is reached twice. The first time, it redirects fetch to the instruction after the split and runs the lanes that were left out. The second time, it restores the mask that was in force before the split. Splits nest, and each nesting level holds one entry in a hardware stack of parameterised depth.

A predicated branch outside this scheme needs all active lanes to agree. If they do not, the block raises a trap request with cause 4. A mask load from the lane spawn and termination logic replaces the mask directly. Each of the four strobes (load, split, join, branch) takes effect at a clock edge. The mask and all the event pulses are registered, so they show the effect of a strobe in the cycle after it.

Top module: `simt_diverge_stack`

## Requirements
- R1: After reset the active mask is lane 0 only (value 1), the stack is empty, and redirect_valid, trap_valid, overflow_err are 0 with trap_cause 0.
- R2: load_valid copies load_mask into the active mask at the next edge, without touching the stack.
- R3: A split with room on the stack pushes an entry and sets the mask to pred AND mask. The entry holds the old mask, the complement (NOT pred AND mask) and split_pc+1.
- R4: A join whose top entry is unvisited and has a non-empty complement sets the mask to that complement and marks the entry visited. In the next cycle it pulses redirect_valid for one cycle, with redirect_pc equal to the stored split_pc+1.
- R5: A join whose top entry is visited restores the stored original mask, pops the entry and gives no redirect.
- R6: A join whose top entry has an empty complement (a unanimous split) restores the original mask and pops at once, with no redirect.
- R7: Nested splits are undone last-in first-out: a join always acts on the most recent unpopped split.
- R8: A split while the stack holds DEPTH entries pulses overflow_err for one cycle. The mask and the stack stay unchanged.
- R9: A join with an empty stack has no effect on the mask and gives no redirect.
- R10: A branch strobe pulses trap_valid, with trap_cause = 4 in that cycle, only when the active lanes hold both true and false predicate bits. Predicate bits of inactive lanes are ignored. trap_cause is 0 whenever trap_valid is 0.
- R11: If several strobes are high in one cycle, only one acts, in the order load, split, join, branch. The others are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_valid | input | 1 | Replace the active mask |
| load_mask | input | LANES | Mask to load |
| pred | input | LANES | Per-lane predicate bits of the current instruction |
| split_valid | input | 1 | Predicated split strobe |
| split_pc | input | PC_W | PC of the split instruction |
| join_valid | input | 1 | Join strobe |
| branch_valid | input | 1 | Predicated control-flow instruction strobe |
| active_mask | output | LANES | Current active lane mask |
| redirect_valid | output | 1 | One-cycle fetch redirect request |
| redirect_pc | output | PC_W | Redirect target |
| trap_valid | output | 1 | One-cycle divergent-branch trap request |
| trap_cause | output | 3 | Trap cause, 4 when trap_valid |
| overflow_err | output | 1 | One-cycle stack overflow error |

## Verification
Directed sequences try two-level nesting with mixed predicates, which tells a LIFO stack apart from one that reverses its order. A unanimous inner split under a divergent outer one tells an early pop apart from a wasted second visit. Filling the stack to DEPTH and then splitting once more exposes overflow handling. Branch predicates that disagree only on masked lanes tell a vote over active lanes apart from a vote over all lanes. Seeded random streams that mix single and simultaneous strobes are then checked cycle by cycle against a reference model in the bench.

// File: rtl/simt_div_pkg.sv
package simt_div_pkg;
  localparam int CAUSE_W = 3;
  localparam logic [CAUSE_W-1:0] CAUSE_DIVERGE = 3'd4;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_LOAD,
    OP_SPLIT,
    OP_JOIN,
    OP_BRANCH
  } div_op_e;
endpackage

// File: rtl/div_vote.sv
module div_vote #(
  parameter int LANES = 8
) (
  input  logic [LANES-1:0] pred,
  input  logic [LANES-1:0] mask,
  output logic [LANES-1:0] taken,
  output logic [LANES-1:0] fallen,
  output logic             diverged
);
  function automatic logic [LANES-1:0] lanes_true(input logic [LANES-1:0] p,
                                                  input logic [LANES-1:0] m);
    return p & m;
  endfunction

  function automatic logic [LANES-1:0] lanes_false(input logic [LANES-1:0] p,
                                                   input logic [LANES-1:0] m);
    return ~p & m;
  endfunction

  assign taken    = lanes_true(pred, mask);
  assign fallen   = lanes_false(pred, mask);
  assign diverged = (|taken) && (|fallen);
endmodule

// File: rtl/div_stack.sv
module div_stack #(
  parameter int LANES = 8,
  parameter int DEPTH = 4,
  parameter int PC_W  = 32,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic             mark,
  input  logic [LANES-1:0] push_orig,
  input  logic [LANES-1:0] push_comp,
  input  logic [PC_W-1:0]  push_pc,
  output logic [LANES-1:0] top_orig,
  output logic [LANES-1:0] top_comp,
  output logic [PC_W-1:0]  top_pc,
  output logic             top_vis,
  output logic             empty,
  output logic             full,
  output logic [CNT_W-1:0] count
);
  logic [LANES-1:0] slot_orig [DEPTH];
  logic [LANES-1:0] slot_comp [DEPTH];
  logic [PC_W-1:0]  slot_pc   [DEPTH];
  logic             slot_vis  [DEPTH];
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] top_idx;

  assign count   = cnt_q;
  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign top_idx = IDX_W'(cnt_q - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (push && !full) cnt_q <= cnt_q + CNT_W'(1);
    else if (pop && !empty) cnt_q <= cnt_q - CNT_W'(1);
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [LANES-1:0] orig_q;
    logic [LANES-1:0] comp_q;
    logic [PC_W-1:0]  pc_q;
    logic             vis_q;
    logic             wr_here;
    logic             mark_here;

    assign wr_here   = push && !full && (cnt_q == CNT_W'(i));
    assign mark_here = mark && (cnt_q == CNT_W'(i + 1));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        orig_q <= '0;
        comp_q <= '0;
        pc_q   <= '0;
        vis_q  <= 1'b0;
      end else if (wr_here) begin
        orig_q <= push_orig;
        comp_q <= push_comp;
        pc_q   <= push_pc;
        vis_q  <= 1'b0;
      end else if (mark_here) begin
        vis_q  <= 1'b1;
      end
    end

    assign slot_orig[i] = orig_q;
    assign slot_comp[i] = comp_q;
    assign slot_pc[i]   = pc_q;
    assign slot_vis[i]  = vis_q;
  end

  assign top_orig = slot_orig[top_idx];
  assign top_comp = slot_comp[top_idx];
  assign top_pc   = slot_pc[top_idx];
  assign top_vis  = slot_vis[top_idx];
endmodule

// File: rtl/simt_diverge_stack.sv
module simt_diverge_stack
  import simt_div_pkg::*;
#(
  parameter int LANES = 8,
  parameter int DEPTH = 4,
  parameter int PC_W  = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_valid,
  input  logic [LANES-1:0]   load_mask,
  input  logic [LANES-1:0]   pred,
  input  logic               split_valid,
  input  logic [PC_W-1:0]    split_pc,
  input  logic               join_valid,
  input  logic               branch_valid,
  output logic [LANES-1:0]   active_mask,
  output logic               redirect_valid,
  output logic [PC_W-1:0]    redirect_pc,
  output logic               trap_valid,
  output logic [CAUSE_W-1:0] trap_cause,
  output logic               overflow_err
);
  function automatic logic [PC_W-1:0] resume_pc(input logic [PC_W-1:0] pc);
    return pc + PC_W'(1);
  endfunction

  div_op_e          op;
  logic [LANES-1:0] mask_q;
  logic [LANES-1:0] vote_taken;
  logic [LANES-1:0] vote_fallen;
  logic             vote_diverged;

  logic [LANES-1:0] stk_orig;
  logic [LANES-1:0] stk_comp;
  logic [PC_W-1:0]  stk_pc;
  logic             stk_vis;
  logic             stk_empty;
  logic             stk_full;
  logic [CNT_W-1:0] stk_count;

  // named internal events
  logic push_ev, pop_ev, mark_ev, ovf_ev, trap_ev;

  always_comb begin
    if (load_valid)        op = OP_LOAD;
    else if (split_valid)  op = OP_SPLIT;
    else if (join_valid)   op = OP_JOIN;
    else if (branch_valid) op = OP_BRANCH;
    else                   op = OP_IDLE;
  end

  div_vote #(.LANES(LANES)) u_vote (
    .pred     (pred),
    .mask     (mask_q),
    .taken    (vote_taken),
    .fallen   (vote_fallen),
    .diverged (vote_diverged)
  );

  assign push_ev = (op == OP_SPLIT) && !stk_full;
  assign ovf_ev  = (op == OP_SPLIT) && stk_full;
  assign mark_ev = (op == OP_JOIN) && !stk_empty && !stk_vis && (stk_comp != '0);
  assign pop_ev  = (op == OP_JOIN) && !stk_empty && (stk_vis || (stk_comp == '0));
  assign trap_ev = (op == OP_BRANCH) && vote_diverged;

  div_stack #(.LANES(LANES), .DEPTH(DEPTH), .PC_W(PC_W)) u_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push_ev),
    .pop       (pop_ev),
    .mark      (mark_ev),
    .push_orig (mask_q),
    .push_comp (vote_fallen),
    .push_pc   (resume_pc(split_pc)),
    .top_orig  (stk_orig),
    .top_comp  (stk_comp),
    .top_pc    (stk_pc),
    .top_vis   (stk_vis),
    .empty     (stk_empty),
    .full      (stk_full),
    .count     (stk_count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q         <= LANES'(1);
      redirect_valid <= 1'b0;
      redirect_pc    <= '0;
      trap_valid     <= 1'b0;
      overflow_err   <= 1'b0;
    end else begin
      if (op == OP_LOAD) mask_q <= load_mask;
      else if (push_ev)  mask_q <= vote_taken;
      else if (mark_ev)  mask_q <= stk_comp;
      else if (pop_ev)   mask_q <= stk_orig;
      redirect_valid <= mark_ev;
      if (mark_ev) redirect_pc <= stk_pc;
      trap_valid   <= trap_ev;
      overflow_err <= ovf_ev;
    end
  end

  assign active_mask = mask_q;
  assign trap_cause  = trap_valid ? CAUSE_DIVERGE : '0;
endmodule

// File: rtl/simt_diverge_chk.sv
module simt_diverge_chk #(
  parameter int LANES = 8,
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             join_valid,
  input logic [LANES-1:0] active_mask,
  input logic             redirect_valid,
  input logic             trap_valid,
  input logic [2:0]       trap_cause,
  input logic             overflow_err,
  input logic [CNT_W-1:0] stk_count,
  input logic             push_ev,
  input logic             pop_ev
);
  AST_SPLIT_NARROWS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(push_ev) |-> ((active_mask & ~$past(active_mask)) == '0)); // R3

  AST_REDIRECT_FROM_JOIN: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> $past(join_valid)); // R4

  AST_REDIRECT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |=> !redirect_valid); // R4

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_err |-> (active_mask == $past(active_mask))); // R8

  AST_STACK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    stk_count <= CNT_W'(DEPTH)); // R7

  AST_POP_NEEDS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ev |-> (stk_count != '0)); // R9

  AST_TRAP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> (trap_cause == 3'd4)); // R10

  AST_CAUSE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_valid |-> (trap_cause == 3'd0)); // R10
endmodule

bind simt_diverge_stack simt_diverge_chk #(.LANES(LANES), .DEPTH(DEPTH)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .join_valid     (join_valid),
  .active_mask    (active_mask),
  .redirect_valid (redirect_valid),
  .trap_valid     (trap_valid),
  .trap_cause     (trap_cause),
  .overflow_err   (overflow_err),
  .stk_count      (stk_count),
  .push_ev        (push_ev),
  .pop_ev         (pop_ev)
);

// File: tb/sim_simt_diverge_stack.sv
`timescale 1ns/1ps
module sim_simt_diverge_stack;
  localparam int L = 8;
  localparam int D = 4;
  localparam int P = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         load_valid = 1'b0;
  logic [L-1:0] load_mask = '0;
  logic [L-1:0] pred = '0;
  logic         split_valid = 1'b0;
  logic [P-1:0] split_pc = '0;
  logic         join_valid = 1'b0;
  logic         branch_valid = 1'b0;
  logic [L-1:0] active_mask;
  logic         redirect_valid;
  logic [P-1:0] redirect_pc;
  logic         trap_valid;
  logic [2:0]   trap_cause;
  logic         overflow_err;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  simt_diverge_stack #(.LANES(L), .DEPTH(D), .PC_W(P)) u0 (
    .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_mask(load_mask),
    .pred(pred), .split_valid(split_valid), .split_pc(split_pc),
    .join_valid(join_valid), .branch_valid(branch_valid),
    .active_mask(active_mask), .redirect_valid(redirect_valid),
    .redirect_pc(redirect_pc), .trap_valid(trap_valid),
    .trap_cause(trap_cause), .overflow_err(overflow_err)
  );

  // reference model state
  logic [L-1:0] m_mask;
  logic [L-1:0] m_orig [D];
  logic [L-1:0] m_comp [D];
  logic [P-1:0] m_pc   [D];
  bit           m_vis  [D];
  int           m_sp;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [P-1:0] act, input logic [P-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit split_disagrees(input logic [L-1:0] p, input logic [L-1:0] m);
    int t = 0;
    int f = 0;
    for (int i = 0; i < L; i++) begin
      if (m[i] && p[i]) t++;
      if (m[i] && !p[i]) f++;
    end
    return (t > 0) && (f > 0);
  endfunction

  task automatic step(input bit ld, input logic [L-1:0] lm, input bit sp,
                      input logic [P-1:0] spc, input bit jn, input bit br,
                      input logic [L-1:0] pr, input string req);
    bit e_redir = 0, e_trap = 0, e_ovf = 0;
    logic [P-1:0] e_rpc = '0;
    load_valid = ld; load_mask = lm; split_valid = sp; split_pc = spc;
    join_valid = jn; branch_valid = br; pred = pr;
    if (ld) m_mask = lm;
    else if (sp) begin
      if (m_sp == D) e_ovf = 1;
      else begin
        m_orig[m_sp] = m_mask;
        m_comp[m_sp] = ~pr & m_mask;
        m_pc[m_sp]   = spc + 1;
        m_vis[m_sp]  = 0;
        m_sp++;
        m_mask = pr & m_mask;
      end
    end else if (jn) begin
      if (m_sp > 0) begin
        int t = m_sp - 1;
        if (!m_vis[t] && m_comp[t] != '0) begin
          m_mask = m_comp[t]; m_vis[t] = 1; e_redir = 1; e_rpc = m_pc[t];
        end else begin
          m_mask = m_orig[t]; m_sp--;
        end
      end
    end else if (br) e_trap = split_disagrees(pr, m_mask);
    @(negedge clk);
    chk(active_mask == m_mask, req, "active_mask", P'(active_mask), P'(m_mask));
    chk(redirect_valid == e_redir, req, "redirect_valid", P'(redirect_valid), P'(e_redir));
    if (e_redir) chk(redirect_pc == e_rpc, req, "redirect_pc", redirect_pc, e_rpc);
    chk(trap_valid == e_trap, req, "trap_valid", P'(trap_valid), P'(e_trap));
    chk(trap_cause == (e_trap ? 3'd4 : 3'd0), req, "trap_cause", P'(trap_cause),
        P'(e_trap ? 3'd4 : 3'd0));
    chk(overflow_err == e_ovf, req, "overflow_err", P'(overflow_err), P'(e_ovf));
    load_valid = 0; split_valid = 0; join_valid = 0; branch_valid = 0;
  endtask

  task automatic do_load(input logic [L-1:0] m, input string r);
    step(1, m, 0, '0, 0, 0, '0, r);
  endtask
  task automatic do_split(input logic [L-1:0] p, input logic [P-1:0] pc, input string r);
    step(0, '0, 1, pc, 0, 0, p, r);
  endtask
  task automatic do_join(input string r);
    step(0, '0, 0, '0, 1, 0, '0, r);
  endtask
  task automatic do_branch(input logic [L-1:0] p, input string r);
    step(0, '0, 0, '0, 0, 1, p, r);
  endtask

  initial begin
    #4000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    m_mask = L'(1);
    m_sp = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(active_mask == L'(1), "R1", "active_mask", P'(active_mask), 1);
    chk(!redirect_valid && !trap_valid && !overflow_err, "R1", "events", 0, 0);
    chk(trap_cause == 3'd0, "R1", "trap_cause", P'(trap_cause), 0);
    do_join("R1_R9");                     // empty stack after reset

    do_load(8'hFF, "R2");
    do_split(8'h0F, 32'd100, "R3");
    do_split(8'h03, 32'd200, "R7");
    do_join("R4");                        // 0x0C, to 201
    do_join("R5");                        // back to 0x0F
    do_join("R4_R7");                     // 0xF0, to 101
    do_join("R5_R7");                     // 0xFF
    do_join("R9");

    do_split(8'h0F, 32'd300, "R3");
    do_split(8'hFF, 32'd400, "R6");      // unanimous
    do_join("R6");                        // pops inner, no redirect
    do_join("R6_R7");                     // outer first visit: redirect 301
    do_join("R5");

    do_load(8'hFF, "R2");
    for (int i = 0; i < D; i++) do_split(8'hFF, 32'(500 + i), "R8");
    do_split(8'h01, 32'd600, "R8");      // overflow
    for (int i = 0; i < D; i++) do_join("R8");
    do_join("R9");

    do_load(8'h0F, "R2");
    do_branch(8'h05, "R10");
    do_branch(8'hF0, "R10");             // only masked lanes true
    do_branch(8'h0F, "R10");
    do_branch(8'hFA, "R10");             // active 0x0A vs 0x05 disagree

    step(1, 8'h3C, 1, 32'd700, 1, 1, 8'h0C, "R11");  // load wins
    step(0, '0, 1, 32'd710, 1, 1, 8'h0C, "R11");     // split wins
    step(0, '0, 0, '0, 1, 1, 8'h04, "R11");          // join wins
    do_join("R11");

    for (int n = 0; n < 500; n++) begin
      int r = int'($urandom % 16);
      logic [L-1:0] pr = L'($urandom);
      logic [P-1:0] pc = P'($urandom % 32'h1000);
      if (r < 2) do_load(L'($urandom) | L'(1), "R2");
      else if (r < 7) do_split(pr, pc, "R3");
      else if (r < 12) do_join("R5");
      else if (r < 15) do_branch(pr, "R10");
      else step($urandom % 2 == 0, L'($urandom), $urandom % 2 == 0, pc,
                $urandom % 2 == 0, 1, pr, "R11");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule